// File: doc/BRIEF.md
# Configurable UART with flow control

A full-duplex asynchronous serial port for one system clock. A programmable divider makes a 16x oversampling tick. The transmitter takes bytes through a valid/ready handshake and sends them as serial frames. The receiver samples incoming frames at the middle of each bit and puts each byte, with its own error flags, into a small buffer that is read through a second valid/ready handshake.

Each instance has its own frame format and handshake mode. A frame carries 7 or 8 data bits, even, odd or no parity, and one or two stop bits. Flow control is off, hardware (clear-to-send input, request-to-send output) or in-band (XON/XOFF characters). With a 100 MHz clock, a divisor of 1 gives 6.25 Mbaud, and a divisor of 20833 gives 300 baud.

Configuration is written through a two-word register port. A written value waits and takes effect only when both directions are between frames.

Top module: `sio_port`

## Requirements
- R1: After reset txd and rtsOut are 1, txReady is 1 and rxValid is 0. The defaults are divisor 1, 8 data bits, no parity, one stop bit and no flow control.
- R2: Every serial bit lasts 16 x divisor clocks. Divisor 0 is treated as 1. In the transmitter, back-to-back frames start one frame length plus about one clock apart.
- R3: A transmitted frame is a 0 start bit, then the data bits least-significant first, then the parity bit if enabled, then one or two stop bits at 1. The line is 1 when idle.
- R4: Mode word bits [2:1] select parity: 0 or 3 none, 1 even, 2 odd. The parity bit makes the number of ones in the data plus the parity bit even or odd, as selected.
- R5: Mode word bit 0 selects the character length: 1 for 8 bits, 0 for 7 bits. In 7-bit mode only txData[6:0] is sent, and received bytes come out with bit 7 at 0.
- R6: A received byte is delivered with rxParErr set when its parity bit does not match, and with rxFrmErr set when its first stop bit is 0. In both cases the data bits are still delivered.
- R7: A low pulse on rxd that is gone by mid-start-bit is rejected and delivers nothing.
- R8: The receive buffer holds RX_DEPTH bytes. The head stays valid and stable until it is taken with rxReady. A byte that completes while the buffer is full is discarded.
- R9: In hardware mode (mode bits [5:4] = 1), a frame starts only while ctsIn is 1. rtsOut goes to 0 when at most one buffer entry is free and returns to 1 when two or more are free. In the other modes rtsOut stays 1.
- R10: In software mode (mode bits [5:4] = 2), a received 0x13 or 0x11 with no error is consumed and not buffered. 0x13 stops new frames once the frame in flight ends, and 0x11 lets them start again. In the other modes these bytes are delivered like any other.
- R11: Writing cfgAddr 0 sets the divisor, and writing cfgAddr 1 sets the mode (bit 3 selects two stop bits). A written value takes effect only when both directions are idle, and no new frame is accepted while a write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 1 | 0: divisor word, 1: mode word |
| cfgWdata | input | DIV_W | Configuration write data |
| txValid | input | 1 | Transmit byte offered |
| txReady | output | 1 | Transmitter accepts a byte |
| txData | input | 8 | Byte to send |
| rxValid | output | 1 | Received byte available |
| rxReady | input | 1 | Consumer takes the head byte |
| rxData | output | 8 | Head received byte |
| rxParErr | output | 1 | Parity error on the head byte |
| rxFrmErr | output | 1 | Framing error on the head byte |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| ctsIn | input | 1 | Remote may receive (1 = yes) |
| rtsOut | output | 1 | Local buffer may accept (1 = yes) |

## Verification
The two functions that can fall in the same cycle are the receiver decoding an XOFF and the transmitter being in the middle of a frame.

The bench provokes this by starting an XOFF on rxd just after the transmitter's start bit appears. Both use two stop bits, so the XOFF is decoded while the outgoing frame is still running.

The check passes when the frame in flight completes intact, txd stays high with txReady low while a second byte waits, nothing reaches the receive buffer, and the waiting byte goes out only after an XON arrives. Receiving a byte while the transmitter is blocked by ctsIn is also exercised.

// File: rtl/sio_pkg.sv
package sio_pkg;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_NONE3 = 2'd3
  } parity_e;

  typedef enum logic [1:0] {
    FLOW_OFF  = 2'd0,
    FLOW_HW   = 2'd1,
    FLOW_SW   = 2'd2,
    FLOW_RSVD = 2'd3
  } flow_e;

  typedef struct packed {
    flow_e   flow;
    logic    twoStop;
    parity_e parity;
    logic    eightBits;
  } frameCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic txAllow;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic txBusy;
    logic rxBusy;
    logic gotXon;
    logic gotXoff;
    logic nearFull;
  } dpStatus_t;

  localparam logic [7:0] XON_CHAR  = 8'h11;
  localparam logic [7:0] XOFF_CHAR = 8'h13;

  localparam frameCfg_t CFG_DEFAULT = '{flow: FLOW_OFF, twoStop: 1'b0,
                                        parity: PAR_NONE, eightBits: 1'b1};

  function automatic frameCfg_t decodeMode(input logic [5:0] w);
    frameCfg_t c;
    c.eightBits = w[0];
    c.parity    = parity_e'(w[2:1]);
    c.twoStop   = w[3];
    c.flow      = flow_e'(w[5:4]);
    return c;
  endfunction

endpackage

// File: rtl/sio_ctrl.sv
module sio_ctrl
  import sio_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgAddr,
  input  logic [DIV_W-1:0] cfgWdata,
  input  logic             ctsIn,
  input  dpStatus_t        st,
  output ctlStrobe_t       strb,
  output frameCfg_t        actCfg,
  output logic             rtsOut
);

  logic [1:0]       ctsSync;
  logic [DIV_W-1:0] divShadow, divAct, divCnt;
  frameCfg_t        modeShadow, modeAct;
  logic             pending, xoffState, rtsQ;
  logic             applyNow, divWrap, flowOk;

  assign applyNow = pending && !cfgWe && !st.txBusy && !st.rxBusy;
  assign divWrap  = (divCnt == divAct - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctsSync    <= '0;
      divShadow  <= DIV_W'(1);
      divAct     <= DIV_W'(1);
      modeShadow <= CFG_DEFAULT;
      modeAct    <= CFG_DEFAULT;
      pending    <= 1'b0;
      divCnt     <= '0;
      xoffState  <= 1'b0;
      rtsQ       <= 1'b1;
    end else begin
      ctsSync <= {ctsSync[0], ctsIn};
      if (cfgWe) begin
        if (!cfgAddr) divShadow <= (cfgWdata == '0) ? DIV_W'(1) : cfgWdata;
        else          modeShadow <= decodeMode(cfgWdata[5:0]);
        pending <= 1'b1;
      end else if (applyNow) begin
        divAct  <= divShadow;
        modeAct <= modeShadow;
        pending <= 1'b0;
      end
      if (applyNow || divWrap) divCnt <= '0;
      else                     divCnt <= divCnt + DIV_W'(1);
      if (modeAct.flow != FLOW_SW) xoffState <= 1'b0;
      else if (st.gotXoff)         xoffState <= 1'b1;
      else if (st.gotXon)          xoffState <= 1'b0;
      rtsQ <= !(modeAct.flow == FLOW_HW && st.nearFull);
    end
  end

  always_comb begin
    unique case (modeAct.flow)
      FLOW_HW: flowOk = ctsSync[1];
      FLOW_SW: flowOk = !xoffState;
      default: flowOk = 1'b1;
    endcase
  end

  assign strb.tick    = divWrap;
  assign strb.txAllow = flowOk && !pending;
  assign actCfg       = modeAct;
  assign rtsOut       = rtsQ;

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.txBusy || st.rxBusy) |=> ($stable(modeAct) && $stable(divAct)));

  // R9
  rts_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeAct.flow == FLOW_HW && st.nearFull) |=> !rtsOut);

  // R10
  xoff_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.gotXoff && modeAct.flow == FLOW_SW) |=> !strb.txAllow);

endmodule

// File: rtl/sio_dpath.sv
module sio_dpath
  import sio_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strb,
  input  frameCfg_t  cfg,
  input  logic       txValid,
  output logic       txReady,
  input  logic [7:0] txData,
  output logic       txd,
  input  logic       rxd,
  output logic       rxValid,
  input  logic       rxReady,
  output logic [7:0] rxData,
  output logic       rxParErr,
  output logic       rxFrmErr,
  output dpStatus_t  st
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rxState_e;

  // shared frame format decode
  logic [3:0] nData, stopIdx;
  logic       parEn, oddSel;
  assign nData   = cfg.eightBits ? 4'd8 : 4'd7;
  assign parEn   = (cfg.parity == PAR_EVEN) || (cfg.parity == PAR_ODD);
  assign oddSel  = (cfg.parity == PAR_ODD);
  assign stopIdx = nData + {3'b0, parEn};

  // ---------------- transmitter ----------------
  logic        txBusy, txdQ, txStart;
  logic [11:0] txSh, frameVec;
  logic [3:0]  txLeft, txPh, frameLen;
  logic [7:0]  dataM;

  always_comb begin
    dataM    = cfg.eightBits ? txData : {1'b0, txData[6:0]};
    frameVec = '1;
    frameVec[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(nData)) frameVec[i+1] = dataM[i];
    end
    if (parEn) frameVec[4'd1 + nData] = (^dataM) ^ oddSel;
    frameLen = 4'd1 + nData + {3'b0, parEn} + (cfg.twoStop ? 4'd2 : 4'd1);
  end

  assign txReady = !txBusy && strb.txAllow;
  assign txStart = txValid && txReady;
  assign txd     = txdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txdQ   <= 1'b1;
      txSh   <= '1;
      txLeft <= '0;
      txPh   <= '0;
    end else if (txStart) begin
      txBusy <= 1'b1;
      txSh   <= frameVec;
      txdQ   <= frameVec[0];
      txLeft <= frameLen;
      txPh   <= '0;
    end else if (txBusy && strb.tick) begin
      txPh <= txPh + 4'd1;
      if (txPh == 4'd15) begin
        if (txLeft == 4'd1) begin
          txBusy <= 1'b0;
          txdQ   <= 1'b1;
        end else begin
          txSh   <= {1'b1, txSh[11:1]};
          txdQ   <= txSh[1];
          txLeft <= txLeft - 4'd1;
        end
      end
    end
  end

  // R2
  txd_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !txStart) |=> $stable(txd));

  // R3
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txd);

  // ---------------- receiver ----------------
  rxState_e   rxState;
  logic [1:0] rxSync;
  logic       rxS, rxPerr, rxDone, isCtrl;
  logic [3:0] rxPh, rxIdx;
  logic [7:0] rxSh;

  assign rxS = rxSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync  <= 2'b11;
      rxState <= RX_IDLE;
      rxPh    <= '0;
      rxIdx   <= '0;
      rxSh    <= '0;
      rxPerr  <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxd};
      if (strb.tick) begin
        unique case (rxState)
          RX_IDLE: if (!rxS) begin
            rxState <= RX_START;
            rxPh    <= '0;
          end
          RX_START: begin
            if (rxPh == 4'd7) begin
              if (!rxS) begin
                rxState <= RX_BITS;
                rxPh    <= '0;
                rxIdx   <= '0;
                rxSh    <= '0;
                rxPerr  <= 1'b0;
              end else begin
                rxState <= RX_IDLE;
              end
            end else begin
              rxPh <= rxPh + 4'd1;
            end
          end
          RX_BITS: begin
            rxPh <= rxPh + 4'd1;
            if (rxPh == 4'd15) begin
              rxIdx <= rxIdx + 4'd1;
              if (rxIdx < nData)         rxSh[rxIdx[2:0]] <= rxS;
              else if (rxIdx != stopIdx) rxPerr <= rxS ^ (^rxSh) ^ oddSel;
              else                       rxState <= RX_IDLE;
            end
          end
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  assign rxDone = strb.tick && (rxState == RX_BITS) && (rxPh == 4'd15) && (rxIdx == stopIdx);
  assign isCtrl = (cfg.flow == FLOW_SW) && rxS && !rxPerr &&
                  ((rxSh == XON_CHAR) || (rxSh == XOFF_CHAR));

  // ---------------- receive buffer ----------------
  logic [9:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             push, pop, full;

  assign full    = (count == CNT_W'(DEPTH));
  assign push    = rxDone && !isCtrl && !full;
  assign rxValid = (count != '0);
  assign pop     = rxValid && rxReady;
  assign {rxParErr, rxFrmErr, rxData} = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {rxPerr, !rxS, rxSh};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      if (pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData)));

  // R10
  ctrl_consume_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && isCtrl && !pop) |=> $stable(count));

  always_comb begin
    st.txBusy   = txBusy;
    st.rxBusy   = (rxState != RX_IDLE);
    st.gotXon   = rxDone && isCtrl && (rxSh == XON_CHAR);
    st.gotXoff  = rxDone && isCtrl && (rxSh == XOFF_CHAR);
    st.nearFull = (count >= CNT_W'(DEPTH - 1));
  end

endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int RX_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic             cfgAddr,
  input  logic [DIV_W-1:0] cfgWdata,
  input  logic             txValid,
  output logic             txReady,
  input  logic [7:0]       txData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic [7:0]       rxData,
  output logic             rxParErr,
  output logic             rxFrmErr,
  output logic             txd,
  input  logic             rxd,
  input  logic             ctsIn,
  output logic             rtsOut
);

  ctlStrobe_t strb;
  dpStatus_t  st;
  frameCfg_t  actCfg;

  sio_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .ctsIn(ctsIn), .st(st), .strb(strb), .actCfg(actCfg), .rtsOut(rtsOut)
  );

  sio_dpath #(.DEPTH(RX_DEPTH)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(actCfg),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txd(txd),
    .rxd(rxd), .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .st(st)
  );

endmodule

// File: tb/tb_sio_port.sv
module tb_sio_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0, cfgAddr = 1'b0;
  logic [15:0] cfgWdata = '0;
  logic        txValid = 1'b0, rxReady = 1'b0, rxd = 1'b1, ctsIn = 1'b1;
  logic [7:0]  txData = '0;
  logic        txReady, rxValid, rxParErr, rxFrmErr, txd, rtsOut;
  logic [7:0]  rxData;

  always #4 clk = ~clk;

  sio_port dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxReady(rxReady), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr),
    .txd(txd), .rxd(rxd), .ctsIn(ctsIn), .rtsOut(rtsOut)
  );

  int checks = 0, failures = 0, cyc = 0, curDiv = 1, benchFlow = 0;
  int rtsBad = 0, idleBad = 0;
  bit rstDone = 0, idleWatch = 0;

  always @(posedge clk) cyc++;

  // per-clock reference comparisons
  always @(negedge clk) begin
    if (rstDone && benchFlow != 1 && rtsOut !== 1'b1) rtsBad++;
    if (idleWatch && txd !== 1'b1) idleBad++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] modeWord(input int eight, input int par, input int two, input int flow);
    return {10'b0, 2'(flow), 1'(two), 2'(par), 1'(eight)};
  endfunction

  task automatic cfgWrite(input logic a, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic setMode(input int eight, input int par, input int two, input int flow);
    cfgWrite(1'b1, modeWord(eight, par, two, flow));
    benchFlow = flow;
  endtask

  task automatic bitOut(input logic v);
    rxd = v;
    repeat (16 * curDiv) @(negedge clk);
  endtask

  task automatic sendRx(input logic [7:0] b, input int nData, input int par, input int nStop,
                        input bit badPar, input bit badStop);
    logic p;
    p = 1'b0;
    @(negedge clk);
    bitOut(1'b0);
    for (int i = 0; i < nData; i++) begin
      bitOut(b[i]);
      p ^= b[i];
    end
    if (par != 0) bitOut(p ^ (par == 2) ^ badPar);
    bitOut(!badStop);
    if (nStop == 2) bitOut(1'b1);
    rxd = 1'b1;
  endtask

  task automatic catchTx(input int nData, input int par, input int nStop,
                         output logic [7:0] d, output bit pOk, output bit sOk, output int startCyc);
    int waitN;
    waitN = 0;
    d = '0; pOk = 1'b0; sOk = 1'b0; startCyc = 0;
    @(negedge clk);
    while (txd !== 1'b0 && waitN < 4000) begin
      @(negedge clk);
      waitN++;
    end
    if (waitN < 4000) begin
      startCyc = cyc;
      repeat (8 * curDiv) @(negedge clk);
      for (int i = 0; i < nData; i++) begin
        repeat (16 * curDiv) @(negedge clk);
        d[i] = txd;
      end
      pOk = 1'b1;
      if (par != 0) begin
        repeat (16 * curDiv) @(negedge clk);
        pOk = (txd == ((^d) ^ (par == 2)));
      end
      sOk = 1'b1;
      for (int s = 0; s < nStop; s++) begin
        repeat (16 * curDiv) @(negedge clk);
        if (txd !== 1'b1) sOk = 1'b0;
      end
    end
  endtask

  task automatic pushTx(input logic [7:0] b);
    @(negedge clk);
    txValid = 1'b1; txData = b;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic popRx(output logic [7:0] d, output logic pe, output logic fe, output bit got);
    int n;
    n = 0;
    got = 1'b0; d = '0; pe = 1'b0; fe = 1'b0;
    @(negedge clk);
    while (!rxValid && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (rxValid) begin
      got = 1'b1; d = rxData; pe = rxParErr; fe = rxFrmErr;
      rxReady = 1'b1;
      @(negedge clk);
      rxReady = 1'b0;
    end
  endtask

  task automatic finishRun();
    chk(rtsBad == 0, "R9", "rtsOut stays 1 outside hardware mode (per clock)", rtsBad, 0);
    chk(idleBad == 0, "R10", "txd held idle in blocked windows (per clock)", idleBad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog run did not complete actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d1, d2;
    logic pe, fe;
    bit p1, s1, p2, s2, got;
    int t1, t2;

    repeat (10) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    rstDone = 1'b1;
    // R1 reset state
    chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
    chk(rtsOut === 1'b1, "R1", "rtsOut after reset", rtsOut, 1);
    chk(txReady === 1'b1, "R1", "txReady after reset", txReady, 1);
    chk(rxValid === 1'b0, "R1", "rxValid after reset", rxValid, 0);

    // R3 / R2: default 8N1, two frames back to back
    fork
      begin pushTx(8'hA5); pushTx(8'h3C); end
      begin
        catchTx(8, 0, 1, d1, p1, s1, t1);
        catchTx(8, 0, 1, d2, p2, s2, t2);
      end
    join
    chk(d1 == 8'hA5 && s1, "R3", "first frame data", d1, 8'hA5);
    chk(d2 == 8'h3C && s2, "R3", "second frame data", d2, 8'h3C);
    chk((t2 - t1) >= 159 && (t2 - t1) <= 163, "R2", "frame spacing at divisor 1", t2 - t1, 161);

    // R4 transmit parity
    setMode(1, 2, 0, 0);
    fork pushTx(8'h0F); catchTx(8, 2, 1, d1, p1, s1, t1); join
    chk(d1 == 8'h0F && p1 && s1, "R4", "odd parity frame", {p1, d1}, 9'h10F);
    setMode(1, 1, 0, 0);
    fork pushTx(8'h07); catchTx(8, 1, 1, d1, p1, s1, t1); join
    chk(d1 == 8'h07 && p1 && s1, "R4", "even parity frame", {p1, d1}, 9'h107);

    // R6 receive parity and framing
    sendRx(8'h96, 8, 1, 1, 0, 0);
    popRx(d1, pe, fe, got);
    chk(got && d1 == 8'h96 && !pe && !fe, "R6", "clean even-parity byte", {pe, fe, d1}, 10'h096);
    sendRx(8'h96, 8, 1, 1, 1, 0);
    popRx(d1, pe, fe, got);
    chk(got && d1 == 8'h96 && pe && !fe, "R6", "parity error flagged", {pe, fe, d1}, 10'h296);
    sendRx(8'h5A, 8, 1, 1, 0, 1);
    popRx(d1, pe, fe, got);
    chk(got && d1 == 8'h5A && !pe && fe, "R6", "framing error flagged", {pe, fe, d1}, 10'h15A);
    repeat (40) @(negedge clk);
    chk(rxValid === 1'b0, "R7", "no byte after framing-error tail", rxValid, 0);

    // R7 false start
    rxd = 1'b0;
    repeat (5) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk(rxValid === 1'b0, "R7", "short low pulse rejected", rxValid, 0);

    // R11 mode written mid-frame applies to the next frame; R5 7-bit
    setMode(1, 0, 0, 0);
    fork
      begin pushTx(8'hC3); pushTx(8'hC5); end
      begin
        catchTx(8, 0, 1, d1, p1, s1, t1);
        catchTx(7, 2, 2, d2, p2, s2, t2);
      end
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (20) @(negedge clk);
        cfgWrite(1'b1, modeWord(0, 2, 1, 0));
      end
    join
    chk(d1 == 8'hC3 && s1, "R11", "frame in flight keeps old format", d1, 8'hC3);
    chk(d2 == 8'h45 && p2 && s2, "R5", "7-bit odd two-stop frame", {p2, s2, d2}, 10'h345);
    sendRx(8'h7F, 7, 2, 2, 0, 0);
    popRx(d1, pe, fe, got);
    chk(got && d1 == 8'h7F && !pe && !fe, "R5", "7-bit receive bit7 zero", {pe, fe, d1}, 10'h07F);

    // R2 divisor 3
    setMode(1, 0, 0, 0);
    cfgWrite(1'b0, 16'd3);
    curDiv = 3;
    fork
      begin pushTx(8'h81); pushTx(8'h42); end
      begin
        catchTx(8, 0, 1, d1, p1, s1, t1);
        catchTx(8, 0, 1, d2, p2, s2, t2);
      end
    join
    chk(d1 == 8'h81 && d2 == 8'h42 && s1 && s2, "R2", "divisor 3 frames data", {d1, d2}, 16'h8142);
    chk((t2 - t1) >= 476 && (t2 - t1) <= 484, "R2", "frame spacing at divisor 3", t2 - t1, 481);
    sendRx(8'hE1, 8, 0, 1, 0, 0);
    popRx(d1, pe, fe, got);
    chk(got && d1 == 8'hE1, "R2", "divisor 3 receive", d1, 8'hE1);
    cfgWrite(1'b0, 16'd1);
    curDiv = 1;

    // R9 hardware flow: transmitter blocked by ctsIn
    setMode(1, 0, 0, 1);
    ctsIn = 1'b0;
    repeat (3) @(negedge clk);
    fork
      pushTx(8'h3C);
      begin
        idleWatch = 1'b1;
        repeat (200) @(negedge clk);
        chk(txReady === 1'b0, "R9", "txReady low while ctsIn low", txReady, 0);
        idleWatch = 1'b0;
        ctsIn = 1'b1;
        catchTx(8, 0, 1, d1, p1, s1, t1);
      end
    join
    chk(d1 == 8'h3C && s1, "R9", "frame sent after ctsIn rises", d1, 8'h3C);

    // R9 / R8 request-to-send threshold and overflow
    sendRx(8'h10, 8, 0, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk(rtsOut === 1'b1, "R9", "rtsOut with three free entries", rtsOut, 1);
    sendRx(8'h20, 8, 0, 1, 0, 0);
    sendRx(8'h30, 8, 0, 1, 0, 0);
    repeat (2) @(negedge clk);
    chk(rtsOut === 1'b0, "R9", "rtsOut drops at one free entry", rtsOut, 0);
    d2 = rxData;
    repeat (20) @(negedge clk);
    chk(rxValid && rxData == d2 && d2 == 8'h10, "R8", "head held while not taken", rxData, 8'h10);
    popRx(d1, pe, fe, got);
    repeat (3) @(negedge clk);
    chk(rtsOut === 1'b1, "R9", "rtsOut back with two free entries", rtsOut, 1);
    sendRx(8'h40, 8, 0, 1, 0, 0);
    sendRx(8'h50, 8, 0, 1, 0, 0);
    sendRx(8'h60, 8, 0, 1, 0, 0);
    for (int k = 0; k < 4; k++) begin
      popRx(d1, pe, fe, got);
      chk(got && d1 == 8'(8'h20 + 8'h10 * k), "R8", "buffer order", d1, 8'h20 + 8'h10 * k);
    end
    popRx(d1, pe, fe, got);
    chk(!got, "R8", "byte into full buffer discarded", got, 0);

    // R10 XOFF arrives during a transmit frame
    setMode(1, 1, 1, 2);
    fork
      begin pushTx(8'h55); pushTx(8'h66); end
      begin
        catchTx(8, 1, 2, d1, p1, s1, t1);
        idleWatch = 1'b1;
        repeat (300) @(negedge clk);
        chk(txReady === 1'b0, "R10", "txReady low after XOFF", txReady, 0);
        chk(rxValid === 1'b0, "R10", "XOFF not buffered", rxValid, 0);
        idleWatch = 1'b0;
        fork
          sendRx(8'h11, 8, 1, 2, 0, 0);
          catchTx(8, 1, 2, d2, p2, s2, t2);
        join
      end
      begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        sendRx(8'h13, 8, 1, 2, 0, 0);
      end
    join
    chk(d1 == 8'h55 && p1 && s1, "R10", "frame in flight completes", d1, 8'h55);
    chk(d2 == 8'h66 && p2 && s2, "R10", "frame resumes after XON", d2, 8'h66);
    repeat (20) @(negedge clk);
    chk(rxValid === 1'b0, "R10", "XON not buffered", rxValid, 0);

    // R10 passthrough when flow control off
    setMode(1, 0, 0, 0);
    sendRx(8'h13, 8, 0, 1, 0, 0);
    popRx(d1, pe, fe, got);
    chk(got && d1 == 8'h13, "R10", "0x13 delivered with flow off", d1, 8'h13);

    finishRun();
  end

endmodule